// File: doc/BRIEF.md
# Four-Context Swap-on-Memory Thread Scheduler

This block decides which of four hardware thread contexts owns a shared single-issue engine. A thread runs until the decode stage reports that it has issued a memory reference marked for a context swap. At that point the thread is put to sleep, the program counter it should resume at is saved in its slot, and after a single dead issue cycle the next ready thread is handed the engine. The sleeping thread stays off the engine until the completion pulse for its reference comes back. One thread's memory latency is thus hidden behind the execution of the other threads.

The engine consumes the active thread index, for example to offset register-file addresses per context, and the active resume PC. All four saved PCs are also visible at all times. When every context is asleep, the valid output drops and the engine idles. The first completion then re-arms a thread with the same one-cycle penalty.

Top module: `ctxSwapSched`

## Requirements
- R1: After reset, context 0 owns the engine (activeValid=1, activeTid=0) and every saved PC is 0. Contexts 1 to 3 are ready.
- R2: While the engine is owned and no swap is accepted, activeValid stays 1 and activeTid does not change.
- R3: A swap is accepted only when swapReq=1, activeValid=1 and swapTid equals activeTid. Any other swap request changes neither the owner nor any saved PC.
- R4: An accepted swap writes swapPc into the PC slot of that context (ctxPcFlat bits [i*PC_W +: PC_W] for context i). activeValid is 0 in the cycle that follows.
- R5: Whenever activeValid is 0 and at least one context is ready, the next edge grants a context. The grant goes to the first ready context in the order last+1, last+2, last+3, last+4 (mod 4), where last is the most recently swapped-out context.
- R6: A swapped-out context is waiting and is never granted until its completion pulse arrives.
- R7: A doneIn pulse for a waiting context makes it ready at that edge. A pulse for a ready or running context is ignored and is not remembered.
- R8: With no ready context, activeValid stays 0. A completion at edge m makes activeValid 1 at edge m+1, with that context as owner.
- R9: If a swap is accepted for a context in the same cycle that its doneIn bit is set, that context becomes ready rather than waiting.
- R10: While activeValid=1, activePc equals the saved PC slot of activeTid.
- R11: At most one context runs at a time, and activeValid is 1 exactly when one does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| swapReq | input | 1 | Decode saw a swap-marked memory reference |
| swapTid | input | 2 | Context that issued the swap reference |
| swapPc | input | PC_W | PC at which the swapping context resumes |
| doneIn | input | 4 | Per-context memory completion pulses |
| activeTid | output | 2 | Context owning the engine |
| activeValid | output | 1 | An owner exists this cycle |
| activePc | output | PC_W | Saved resume PC of the owner |
| ctxPcFlat | output | 4*PC_W | All four saved PCs, context i at [i*PC_W +: PC_W] |

## Verification
A swap and a completion can land in the same cycle, either for the same context or for different ones. Only the same-context case changes the result: it must leave that context ready, and it is regranted only after the others. The bench forces both cases in directed steps, and its random phase pulses completions on every context while swaps are requested. Each cycle it compares the owner, valid and all PC slots against a behavioural model that applies completions before swaps.

// File: rtl/ctxSwapPkg.sv
package ctxSwapPkg;
  localparam int NUM_CTX = 4;
  localparam int TID_W = $clog2(NUM_CTX);

  typedef enum logic [1:0] {
    CTX_READY   = 2'd0,
    CTX_RUNNING = 2'd1,
    CTX_WAITING = 2'd2
  } ctxState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             swapTake;
    logic [TID_W-1:0] swapTid;
    logic             grant;
    logic [TID_W-1:0] grantTid;
  } ctxStrobe_t;
endpackage

// File: rtl/ctxRrPick.sv
module ctxRrPick #(
  parameter int N = 4,
  parameter int TID_W = 2
) (
  input  logic [N-1:0]     readyMask,
  input  logic [TID_W-1:0] lastTid,
  output logic             found,
  output logic [TID_W-1:0] pickTid
);
  // scan farthest first so the nearest ready context after lastTid wins
  always_comb begin
    found = 1'b0;
    pickTid = lastTid;
    for (int k = N; k >= 1; k--) begin
      int idx;
      idx = (int'(lastTid) + k) % N;
      if (readyMask[idx]) begin
        found = 1'b1;
        pickTid = TID_W'(idx);
      end
    end
  end
endmodule

// File: rtl/ctxSwapCtrl.sv
module ctxSwapCtrl import ctxSwapPkg::*; (
  input  logic               clk,
  input  logic               rstN,
  input  logic               swapReq,
  input  logic [TID_W-1:0]   swapTid,
  input  logic [NUM_CTX-1:0] doneIn,
  input  logic [TID_W-1:0]   activeTid,
  input  logic               activeValid,
  output ctxStrobe_t         strb,
  output logic [NUM_CTX-1:0] readyMask,
  output logic [NUM_CTX-1:0] runMask,
  output logic [NUM_CTX-1:0] waitMask
);
  ctxState_e ctxSt [NUM_CTX];
  logic [TID_W-1:0] lastTid;
  logic pickFound;
  logic [TID_W-1:0] pickTid;

  ctxRrPick #(.N(NUM_CTX), .TID_W(TID_W)) pick_i (
    .readyMask(readyMask),
    .lastTid(lastTid),
    .found(pickFound),
    .pickTid(pickTid)
  );

  always_comb begin
    strb.swapTake = swapReq && activeValid && (swapTid == activeTid);
    strb.swapTid  = swapTid;
    strb.grant    = !activeValid && pickFound;
    strb.grantTid = pickTid;
  end

  for (genvar g = 0; g < NUM_CTX; g++) begin : g_ctx
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ctxSt[g] <= (g == 0) ? CTX_RUNNING : CTX_READY;
      end else if (strb.swapTake && strb.swapTid == TID_W'(g)) begin
        ctxSt[g] <= doneIn[g] ? CTX_READY : CTX_WAITING;
      end else if (strb.grant && strb.grantTid == TID_W'(g)) begin
        ctxSt[g] <= CTX_RUNNING;
      end else if (doneIn[g] && ctxSt[g] == CTX_WAITING) begin
        ctxSt[g] <= CTX_READY;
      end
    end
    assign readyMask[g] = (ctxSt[g] == CTX_READY);
    assign runMask[g]   = (ctxSt[g] == CTX_RUNNING);
    assign waitMask[g]  = (ctxSt[g] == CTX_WAITING);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastTid <= '0;
    else if (strb.swapTake) lastTid <= swapTid;
  end
endmodule

// File: rtl/ctxSwapData.sv
module ctxSwapData import ctxSwapPkg::*; #(
  parameter int PC_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctxStrobe_t              strb,
  input  logic [PC_W-1:0]         swapPc,
  output logic [TID_W-1:0]        activeTid,
  output logic                    activeValid,
  output logic [PC_W-1:0]         activePc,
  output logic [NUM_CTX*PC_W-1:0] ctxPcFlat
);
  logic [PC_W-1:0] pcFile [NUM_CTX];

  for (genvar g = 0; g < NUM_CTX; g++) begin : g_pc
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pcFile[g] <= '0;
      else if (strb.swapTake && strb.swapTid == TID_W'(g)) pcFile[g] <= swapPc;
    end
    assign ctxPcFlat[g*PC_W +: PC_W] = pcFile[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeTid <= '0;
      activeValid <= 1'b1;
    end else if (strb.swapTake) begin
      activeValid <= 1'b0;
    end else if (strb.grant) begin
      activeValid <= 1'b1;
      activeTid <= strb.grantTid;
    end
  end

  assign activePc = pcFile[activeTid];
endmodule

// File: rtl/ctxSwapSched.sv
module ctxSwapSched import ctxSwapPkg::*; #(
  parameter int PC_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    swapReq,
  input  logic [TID_W-1:0]        swapTid,
  input  logic [PC_W-1:0]         swapPc,
  input  logic [NUM_CTX-1:0]      doneIn,
  output logic [TID_W-1:0]        activeTid,
  output logic                    activeValid,
  output logic [PC_W-1:0]         activePc,
  output logic [NUM_CTX*PC_W-1:0] ctxPcFlat
);
  ctxStrobe_t strb;
  logic [NUM_CTX-1:0] readyMask;
  logic [NUM_CTX-1:0] runMask;
  logic [NUM_CTX-1:0] waitMask;

  ctxSwapCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .swapReq(swapReq), .swapTid(swapTid),
    .doneIn(doneIn), .activeTid(activeTid), .activeValid(activeValid),
    .strb(strb), .readyMask(readyMask), .runMask(runMask), .waitMask(waitMask)
  );

  ctxSwapData #(.PC_W(PC_W)) data_i (
    .clk(clk), .rstN(rstN), .strb(strb), .swapPc(swapPc),
    .activeTid(activeTid), .activeValid(activeValid),
    .activePc(activePc), .ctxPcFlat(ctxPcFlat)
  );
endmodule

// File: rtl/ctxSwapChk.sv
module ctxSwapChk import ctxSwapPkg::*; (
  input logic               clk,
  input logic               rstN,
  input logic               swapReq,
  input logic [TID_W-1:0]   swapTid,
  input logic [NUM_CTX-1:0] doneIn,
  input logic [TID_W-1:0]   activeTid,
  input logic               activeValid,
  input logic [NUM_CTX-1:0] readyMask,
  input logic [NUM_CTX-1:0] runMask,
  input logic [NUM_CTX-1:0] waitMask
);
  logic [NUM_CTX-1:0] prevReady;
  logic accepted;
  assign accepted = swapReq && activeValid && (swapTid == activeTid);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevReady <= '0;
    else prevReady <= readyMask;
  end

  AST_HOLD_OWNER: assert property (@(posedge clk) disable iff (!rstN)
    activeValid && !accepted |=> activeValid && $stable(activeTid)); // R2
  AST_SWAP_BUBBLE: assert property (@(posedge clk) disable iff (!rstN)
    accepted |=> !activeValid); // R4
  AST_GRANT_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    !activeValid && (readyMask != '0) |=> activeValid); // R5
  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    !activeValid && (readyMask == '0) |=> !activeValid); // R8
  AST_SLEEP: assert property (@(posedge clk) disable iff (!rstN)
    accepted && !doneIn[swapTid] |=> waitMask[$past(swapTid)]); // R6
  AST_NO_LOST_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    accepted && doneIn[swapTid] |=> readyMask[$past(swapTid)]); // R9
  AST_GRANT_WAS_READY: assert property (@(posedge clk) disable iff (!rstN)
    activeValid && !$past(activeValid) |-> prevReady[activeTid]); // R6
  AST_ONE_RUNNER: assert property (@(posedge clk) disable iff (!rstN)
    $countones(runMask) <= 1 && (activeValid == (runMask != '0))); // R11
endmodule

bind ctxSwapSched ctxSwapChk chk_i (
  .clk(clk), .rstN(rstN), .swapReq(swapReq), .swapTid(swapTid),
  .doneIn(doneIn), .activeTid(activeTid), .activeValid(activeValid),
  .readyMask(readyMask), .runMask(runMask), .waitMask(waitMask)
);

// File: tb/ctxSwapSched_tb_top.sv
`timescale 1ns/1ps
module ctxSwapSched_tb_top;
  localparam int PC_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic swapReq = 1'b0;
  logic [1:0] swapTid = '0;
  logic [PC_W-1:0] swapPc = '0;
  logic [3:0] doneIn = '0;
  logic [1:0] activeTid;
  logic activeValid;
  logic [PC_W-1:0] activePc;
  logic [4*PC_W-1:0] ctxPcFlat;

  always #2 clk = ~clk;

  ctxSwapSched #(.PC_W(PC_W)) dut_i (
    .clk(clk), .rstN(rstN), .swapReq(swapReq), .swapTid(swapTid),
    .swapPc(swapPc), .doneIn(doneIn), .activeTid(activeTid),
    .activeValid(activeValid), .activePc(activePc), .ctxPcFlat(ctxPcFlat)
  );

  // behavioural model: 0 ready, 1 running, 2 waiting
  int mSt [4];
  int mPc [4];
  int mAct, mLast;
  bit mVal;
  int nRun = 0, nFail = 0;
  bit finished = 0;

  task automatic modelReset();
    for (int i = 0; i < 4; i++) begin mSt[i] = (i == 0) ? 1 : 0; mPc[i] = 0; end
    mAct = 0; mVal = 1; mLast = 0;
  endtask

  task automatic modelStep(input bit sr, input int st, input int sp, input logic [3:0] dn);
    int old [4];
    bit take;
    for (int i = 0; i < 4; i++) old[i] = mSt[i];
    take = sr && mVal && (st == mAct);
    for (int i = 0; i < 4; i++) if (dn[i] && old[i] == 2) mSt[i] = 0;
    if (take) begin
      mPc[st] = sp;
      mSt[st] = dn[st] ? 0 : 2;
      mVal = 0;
      mLast = st;
    end else if (!mVal) begin
      for (int k = 1; k <= 4; k++) begin
        int idx;
        idx = (mLast + k) % 4;
        if (old[idx] == 0) begin
          mSt[idx] = 1; mAct = idx; mVal = 1;
          break;
        end
      end
    end
  endtask

  task automatic check(input string tag, input string what, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    check(tag, "activeValid", int'(activeValid), int'(mVal));
    if (mVal) begin
      check(tag, "activeTid", int'(activeTid), mAct);
      check("R10", "activePc", int'(activePc), mPc[mAct]);
    end
    for (int i = 0; i < 4; i++)
      check(tag, $sformatf("ctxPc[%0d]", i), int'(ctxPcFlat[i*PC_W +: PC_W]), mPc[i]);
  endtask

  // compare state after the last edge, then drive inputs for the next edge
  task automatic step(input bit sr, input int st, input int sp, input logic [3:0] dn, input string tag);
    @(negedge clk);
    compare(tag);
    swapReq = sr; swapTid = 2'(st); swapPc = PC_W'(sp); doneIn = dn;
    modelStep(sr, st, sp, dn);
  endtask

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step(0, 0, 0, 4'b0000, "R1");             // reset state checked here
    step(0, 0, 0, 4'b0011, "R7");             // done on running/ready ignored
    step(0, 0, 0, 4'b0000, "R2");
    step(1, 2, 16'h1111, 4'b0000, "R3");      // wrong context, ignored
    step(0, 0, 0, 4'b0000, "R3");
    step(1, 0, 16'h0040, 4'b0000, "R4");      // ctx0 out
    step(0, 0, 0, 4'b0000, "R4");             // bubble
    step(0, 0, 0, 4'b0000, "R5");             // ctx1 owns
    step(1, 1, 16'h0080, 4'b0001, "R5");      // ctx1 out, ctx0 wakes
    step(0, 0, 0, 4'b0000, "R5");
    step(0, 0, 0, 4'b0000, "R5");             // ctx2 owns
    step(1, 2, 16'h00c0, 4'b0000, "R5");
    step(0, 0, 0, 4'b0000, "R5");
    step(0, 0, 0, 4'b0000, "R5");             // ctx3 owns
    step(1, 3, 16'h0100, 4'b0000, "R6");
    step(0, 0, 0, 4'b0000, "R6");
    step(0, 0, 0, 4'b0000, "R10");            // ctx0 back at 0x40
    step(1, 0, 16'h0044, 4'b0001, "R9");      // swap and done same ctx
    step(0, 0, 0, 4'b0000, "R9");
    step(0, 0, 0, 4'b0000, "R9");             // ctx0 regranted
    step(1, 0, 16'h0048, 4'b0000, "R8");      // all waiting now
    step(0, 0, 0, 4'b0000, "R8");
    step(0, 0, 0, 4'b0000, "R8");
    step(0, 0, 0, 4'b0000, "R8");
    step(0, 0, 0, 4'b0100, "R8");             // ctx2 completes
    step(0, 0, 0, 4'b0000, "R8");
    step(0, 0, 0, 4'b0000, "R8");             // ctx2 owns
    for (int n = 0; n < 2000; n++) begin
      bit sr;
      int st;
      logic [3:0] dn;
      sr = ($urandom % 10) < 3;
      st = (($urandom % 4) < 3) ? mAct : int'($urandom % 4);
      for (int i = 0; i < 4; i++) dn[i] = ($urandom % 5) == 0;
      step(sr, st, int'($urandom % 65536), dn, "R5");
    end
    step(0, 0, 0, 4'b0000, "R2");
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired (R2) actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule